// File: doc/BRIEF.md
# Vector register remap unit

This unit turns a 5-bit architectural register number into a 6-bit physical register number. It keeps two configuration tables of 32 entries each, one for integer operands and one for floating-point operands. Each entry carries an enable flag, a vector flag and a 6-bit target index. A disabled entry passes the register number through unchanged. An enabled scalar entry redirects to its target, which gives access to all 64 physical registers. An enabled vector entry redirects to its target plus the current element offset. That makes a run of consecutive physical registers behave as one vector operand.

For any enabled entry, the result also passes through a predicate test. One mask bit is chosen by the element offset. When that bit is clear, the output is forced to physical register 0. A loop-continue flag tells the element sequencer that the operand is a vector, so it should issue the next element. The tables are loaded through a simple write port. The lookup is registered once, so each result appears one cycle after its request.

Top module: `vreg_remap_unit`

## Requirements
- R1: Each table has 32 entries keyed by the 5-bit register number, and a stored 6-bit target can name any physical register from 0 to 63 (for example, entry 31 may target register 63).
- R2: The integer table is used when `lk_fp` is 0 and the floating-point table when it is 1. A write with `cfg_fp` set alters only the floating-point table, and a write with `cfg_fp` clear alters only the integer table.
- R3: When the selected entry is disabled, `res_preg` equals the requested register number zero-extended to 6 bits, `res_loop` is 0, and the predicate mask has no effect.
- R4: When the selected entry is enabled with the vector flag clear, `res_preg` is the stored target, `res_loop` is 0, and the element offset is not added.
- R5: When the selected entry is enabled with the vector flag set, `res_preg` is (target + element offset) modulo 64.
- R6: For an enabled entry, if bit `lk_offs` of `lk_mask` (bit 0 being the least significant) is 0, `res_preg` is 0.
- R7: When the selected entry is enabled with the vector flag set, `res_loop` is 1, whatever the predicate bit.
- R8: A table write takes effect at the clock edge ending the cycle in which `cfg_we` is high. A lookup presented in that same cycle sees the old entry, and a lookup in the next cycle sees the new one.
- R9: `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid` high, and `res_preg` and `res_loop` in that cycle belong to that request.
- R10: Synchronous reset clears every entry of both tables, so every lookup becomes an identity mapping, and it clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_fp | input | 1 | Write targets the floating-point table (1) or the integer table (0) |
| cfg_areg | input | 5 | Entry to write |
| cfg_active | input | 1 | Enable flag to store |
| cfg_vec | input | 1 | Vector flag to store |
| cfg_target | input | 6 | Target physical register to store |
| lk_valid | input | 1 | Lookup request strobe |
| lk_fp | input | 1 | Lookup uses the floating-point table (1) or the integer table (0) |
| lk_areg | input | 5 | Architectural register to translate |
| lk_offs | input | 6 | Element offset, unsigned |
| lk_mask | input | 64 | Predicate mask, one bit per element offset |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_preg | output | 6 | Translated physical register |
| res_loop | output | 1 | Operand is a vector; the sequencer should continue |

## Verification
The assertions take for granted that every request and write input is a known value whenever its strobe is high. They also assume `lk_valid` is not asserted during reset, since the result checks compare against inputs and table contents from the previous cycle. The stimulus drives all inputs on the falling clock edge with defined values. It holds both strobes low during reset and keeps the mask, offset and register fields at zero when idle. This means no check ever sees an unknown table read. Writes and lookups to the same entry in one cycle are issued on purpose, so that the old-value ordering is exercised.

// File: rtl/vremap_pkg.sv
package vremap_pkg;

    localparam int AREG_W   = 5;
    localparam int PREG_W   = 6;
    localparam int OFFS_W   = 6;
    localparam int MASK_W   = 1 << OFFS_W;
    localparam int NUM_AREG = 1 << AREG_W;
    localparam int NUM_KIND = 2;

    typedef enum logic {
        KIND_INT = 1'b0,
        KIND_FP  = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic              active;
        logic              isvec;
        logic [PREG_W-1:0] target;
    } map_entry_t;

    typedef struct packed {
        logic              loop;
        logic [PREG_W-1:0] preg;
    } remap_res_t;

    function automatic logic [PREG_W-1:0] widen_areg(input logic [AREG_W-1:0] a);
        return PREG_W'(a);
    endfunction

    function automatic logic pred_bit(input logic [MASK_W-1:0] m,
                                      input logic [OFFS_W-1:0] o);
        return m[o];
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table
    import vremap_pkg::*;
#(
    parameter int DEPTH  = NUM_AREG,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  map_entry_t        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output map_entry_t        rd_data
);

    map_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R8
    wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/remap_calc.sv
module remap_calc
    import vremap_pkg::*;
(
    input  logic [AREG_W-1:0] areg,
    input  logic [OFFS_W-1:0] offs,
    input  logic [MASK_W-1:0] mask,
    input  map_entry_t        entry,
    output remap_res_t        res
);

    logic [PREG_W-1:0] base;
    logic [PREG_W-1:0] stepped;
    logic              keep;

    always_comb begin
        base    = entry.target;
        stepped = entry.isvec ? PREG_W'(base + PREG_W'(offs)) : base;
        keep    = pred_bit(mask, offs);
        res     = '0;
        if (!entry.active) begin
            res.preg = widen_areg(areg);
            res.loop = 1'b0;
        end else begin
            res.preg = keep ? stepped : '0;
            res.loop = entry.isvec;
        end
    end

endmodule

// File: rtl/vreg_remap_unit.sv
module vreg_remap_unit
    import vremap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_fp,
    input  logic [AREG_W-1:0] cfg_areg,
    input  logic              cfg_active,
    input  logic              cfg_vec,
    input  logic [PREG_W-1:0] cfg_target,
    input  logic              lk_valid,
    input  logic              lk_fp,
    input  logic [AREG_W-1:0] lk_areg,
    input  logic [OFFS_W-1:0] lk_offs,
    input  logic [MASK_W-1:0] lk_mask,
    output logic              res_valid,
    output logic [PREG_W-1:0] res_preg,
    output logic              res_loop
);

    map_entry_t wr_entry;
    map_entry_t kind_rd [NUM_KIND];
    map_entry_t sel_entry;
    remap_res_t calc_res;
    remap_res_t res_q;
    logic       valid_q;

    assign wr_entry = '{active: cfg_active, isvec: cfg_vec, target: cfg_target};

    for (genvar k = 0; k < NUM_KIND; k++) begin : g_tbl
        logic kind_we;
        assign kind_we = cfg_we && (cfg_fp == k[0]);
        remap_table #(.DEPTH(NUM_AREG)) tbl_i (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (kind_we),
            .wr_addr (cfg_areg),
            .wr_data (wr_entry),
            .rd_addr (lk_areg),
            .rd_data (kind_rd[k])
        );
    end

    assign sel_entry = (reg_kind_e'(lk_fp) == KIND_FP) ? kind_rd[KIND_FP] : kind_rd[KIND_INT];

    remap_calc calc_i (
        .areg  (lk_areg),
        .offs  (lk_offs),
        .mask  (lk_mask),
        .entry (sel_entry),
        .res   (calc_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= lk_valid;
            if (lk_valid) begin
                res_q <= calc_res;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_preg  = res_q.preg;
    assign res_loop  = res_q.loop;

    // R9
    res_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R9
    no_spurious_res_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R3
    identity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !sel_entry.active) |=>
            (res_preg == PREG_W'($past(lk_areg)) && !res_loop));

    // R6
    pred_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && sel_entry.active && !lk_mask[lk_offs]) |=> (res_preg == '0));

    // R7
    vec_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && sel_entry.active && sel_entry.isvec) |=> res_loop);

    // R4
    scalar_noloop_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && sel_entry.active && !sel_entry.isvec) |=> !res_loop);

endmodule

// File: tb/vreg_remap_unit_tb_top.sv
module vreg_remap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_fp = 1'b0;
    logic [4:0]  cfg_areg = '0;
    logic        cfg_active = 1'b0;
    logic        cfg_vec = 1'b0;
    logic [5:0]  cfg_target = '0;
    logic        lk_valid = 1'b0;
    logic        lk_fp = 1'b0;
    logic [4:0]  lk_areg = '0;
    logic [5:0]  lk_offs = '0;
    logic [63:0] lk_mask = '0;
    logic        res_valid;
    logic [5:0]  res_preg;
    logic        res_loop;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [5:0] preg;
        logic       loop;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic       m_act [2][32];
    logic       m_vec [2][32];
    logic [5:0] m_tgt [2][32];

    always #5 clk = ~clk;

    vreg_remap_unit dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_fp(cfg_fp), .cfg_areg(cfg_areg),
        .cfg_active(cfg_active), .cfg_vec(cfg_vec), .cfg_target(cfg_target),
        .lk_valid(lk_valid), .lk_fp(lk_fp), .lk_areg(lk_areg),
        .lk_offs(lk_offs), .lk_mask(lk_mask),
        .res_valid(res_valid), .res_preg(res_preg), .res_loop(res_loop)
    );

    function automatic exp_t model(input bit fp, input logic [4:0] a,
                                   input logic [5:0] o, input logic [63:0] m,
                                   input string tag);
        exp_t e;
        e.tag = tag;
        if (!m_act[fp][a]) begin
            e.preg = {1'b0, a};
            e.loop = 1'b0;
        end else begin
            e.preg = m_vec[fp][a] ? 6'(m_tgt[fp][a] + o) : m_tgt[fp][a];
            if (!m[o]) e.preg = 6'd0;
            e.loop = m_vec[fp][a];
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 32; i++) begin
                m_act[k][i] = 1'b0; m_vec[k][i] = 1'b0; m_tgt[k][i] = '0;
            end
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        lk_areg = '0; lk_offs = '0; lk_mask = '0;
    endtask

    task automatic drive_write(input bit fp, input logic [4:0] a, input bit act,
                               input bit vec, input logic [5:0] tgt);
        cfg_we = 1'b1; cfg_fp = fp; cfg_areg = a;
        cfg_active = act; cfg_vec = vec; cfg_target = tgt;
    endtask

    task automatic drive_lookup(input bit fp, input logic [4:0] a, input logic [5:0] o,
                                input logic [63:0] m, input string tag);
        lk_valid = 1'b1; lk_fp = fp; lk_areg = a; lk_offs = o; lk_mask = m;
        exp_q.push_back(model(fp, a, o, m, tag));
    endtask

    task automatic wr(input bit fp, input logic [4:0] a, input bit act,
                      input bit vec, input logic [5:0] tgt);
        @(negedge clk);
        lk_valid = 1'b0;
        drive_write(fp, a, act, vec, tgt);
        m_act[fp][a] = act; m_vec[fp][a] = vec; m_tgt[fp][a] = tgt;
    endtask

    task automatic lookup(input bit fp, input logic [4:0] a, input logic [5:0] o,
                          input logic [63:0] m, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        drive_lookup(fp, a, o, m, tag);
    endtask

    // R8: write and lookup in one cycle; expectation taken before the model update
    task automatic wr_and_lookup(input bit fp, input logic [4:0] a, input bit act,
                                 input bit vec, input logic [5:0] tgt, input string tag);
        @(negedge clk);
        drive_lookup(fp, a, 6'd0, '1, tag);
        drive_write(fp, a, act, vec, tgt);
        m_act[fp][a] = act; m_vec[fp][a] = vec; m_tgt[fp][a] = tgt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; lk_valid = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        clear_model();
        rst = 1'b0;
    endtask

    // Monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 result without request", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_preg == e.preg, {e.tag, " preg"}, int'(res_preg), int'(e.preg));
                check(res_loop == e.loop, {e.tag, " loop"}, int'(res_loop), int'(e.loop));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_model();
        do_reset();
        @(negedge clk);
        check(res_valid == 1'b0, "R10 res_valid after reset", int'(res_valid), 0);

        // R10 / R3: identity after reset, mask ignored
        lookup(0, 5'd0,  6'd0, 64'd0, "R10 int0 identity");
        lookup(0, 5'd5,  6'd3, 64'd0, "R3 int5 identity mask ignored");
        lookup(1, 5'd31, 6'd9, 64'd0, "R3 fp31 identity");
        idle();

        // R4 scalar redirect, R2 table independence
        wr(0, 5'd5, 1, 0, 6'd35);
        lookup(0, 5'd5, 6'd0, '1, "R4 int5 scalar redirect");
        lookup(0, 5'd5, 6'd7, '1, "R4 scalar offset not added");
        lookup(1, 5'd5, 6'd0, '1, "R2 fp5 untouched by int write");
        lookup(0, 5'd5, 6'd2, 64'hFFFF_FFFF_FFFF_FFFB, "R6 scalar predicate clear");
        // R5 / R7 vector
        wr(1, 5'd5, 1, 1, 6'd40);
        lookup(1, 5'd5, 6'd3,  '1, "R5 fp5 vector +3");
        lookup(1, 5'd5, 6'd30, '1, "R5 vector wrap mod 64");
        lookup(1, 5'd5, 6'd30, ~(64'd1 << 30), "R7 loop with predicate clear");
        lookup(1, 5'd5, 6'd63, 64'd1 << 63, "R6 top mask bit selects");
        lookup(0, 5'd5, 6'd0, '1, "R2 int5 still scalar");
        // R1 full target range
        wr(0, 5'd31, 1, 0, 6'd63);
        lookup(0, 5'd31, 6'd0, '1, "R1 int31 to 63");
        // R8 same-cycle ordering
        wr_and_lookup(0, 5'd7, 1, 0, 6'd50, "R8 same-cycle sees old");
        lookup(0, 5'd7, 6'd0, '1, "R8 next cycle sees new");
        // R3 disable again
        wr(0, 5'd5, 0, 1, 6'd12);
        lookup(0, 5'd5, 6'd4, 64'd0, "R3 disabled entry identity");
        idle();

        // Mixed stream with writes interleaved
        for (int i = 0; i < 200; i++) begin
            logic [31:0] h;
            h = 32'(i) * 32'h9E37_79B9 + 32'h1234_5677;
            if (h[3:0] == 4'd0)
                wr(h[4], h[9:5], h[10], h[11], h[17:12]);
            else
                lookup(h[4], h[9:5], h[23:18], {h, ~h} ^ {32'h5A5A_A5A5, h}, "R9 stream");
        end
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results returned", exp_q.size(), 0);

        // R10 reset mid-run restores identity
        wr(1, 5'd9, 1, 1, 6'd20);
        idle();
        do_reset();
        lookup(1, 5'd9, 6'd1, '1, "R10 identity after second reset");
        idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule